// File: doc/BRIEF.md
# Processor Interrupt Delivery Unit

This block sits between the interrupt sources of a chip and one processor core and decides, cycle by cycle, which exception the core is told about. Three kinds of request come in as single-cycle events: a reset request, a non-maskable request, and a 6-bit maskable level, one bit per hardware interrupt line. Each event is latched into a pending record, and a fixed-priority arbiter serves at most one pending record per cycle.

Reset and non-maskable requests share one exception strobe. A maskable level is written into a 6-bit pending field that the core reads as part of its cause register. It is delivered as an interrupt strobe only when the core's global enable bit is set and the level shares a line with the core's mask field. A masked or disabled level stays pending and is looked at again every cycle. A level value of zero is an end-of-interrupt marker: it wipes the cause field and raises no exception.

Top module: `irq_delivery_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every pending record, and after it `resnmi_o`, `irq_o` and `cause_ip_o` are zero; a level that was pending before the reset is never delivered after it.
- R2: A reset request pulse at clock edge k produces a one-cycle `resnmi_o` pulse after edge k+1.
- R3: Pending records are served in the order reset request, then non-maskable request, then maskable level, one per cycle; a reset request and a non-maskable request captured together give two consecutive `resnmi_o` pulses, and a maskable level captured with them is served in the cycle after those.
- R4: A maskable event with a nonzero level loads that level into `cause_ip_o` (bit i set for line i) when it is served, whether or not it is delivered; `cause_ip_o` changes only when a maskable record is served.
- R5: A maskable event with level zero is an end-of-interrupt marker: when served it clears `cause_ip_o` to zero, raises no strobe, and ends any level still pending.
- R6: `irq_o` pulses only when, in the serving cycle, `ie_i` is 1 and the pending level ANDed with `mask_i` is nonzero; a delivered level is then no longer pending and gives no second pulse.
- R7: A pending level that is masked or disabled stays pending for any number of cycles and is delivered in the first cycle in which `ie_i` and `mask_i` allow it.
- R8: An event that arrives in the same cycle as its own kind of record is served replaces that record and is served in the next cycle, so it is not lost.
- R9: `resnmi_o` and `irq_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| rst_req_i | input | 1 | Reset request event, one cycle |
| nmi_req_i | input | 1 | Non-maskable request event, one cycle |
| lvl_vld_i | input | 1 | Maskable level event strobe, one cycle |
| lvl_i | input | 6 | Maskable level; zero means end of interrupt |
| ie_i | input | 1 | Core global interrupt enable |
| mask_i | input | 6 | Core per-line interrupt mask |
| resnmi_o | output | 1 | Reset/non-maskable exception strobe |
| irq_o | output | 1 | Maskable interrupt exception strobe |
| cause_ip_o | output | 6 | Hardware interrupt pending field of the cause register |

## Verification
The assertions watch on every cycle that a pending reset request always yields the shared strobe next cycle, that a non-maskable request is served when no reset request is ahead of it, that every interrupt strobe was enabled and unmasked in the cycle before, that a masked level keeps its pending state, that the cause field only moves when a level record is served, and that both strobes never coincide. Only the bench scenarios show the end-to-end ordering of three requests captured together, the overriding of a record by a fresh event in its serving cycle, a level waiting through many disabled cycles before delivery, and the loss of pending state on a block reset.

// File: rtl/idu_pkg.sv
package idu_pkg;
  typedef enum logic [1:0] {
    LV_IDLE = 2'd0,
    LV_SET  = 2'd1,
    LV_CLR  = 2'd2
  } lvl_st_e;
endpackage

// File: rtl/idu_pending.sv
module idu_pending
  import idu_pkg::*;
#(
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_rst,
  input  logic          ev_nmi,
  input  logic          ev_lvl,
  input  logic [LW-1:0] ev_lvl_val,
  input  logic          take_rst,
  input  logic          take_nmi,
  input  logic          take_lvl,
  output logic          p_rst,
  output logic          p_nmi,
  output lvl_st_e       p_st,
  output logic [LW-1:0] p_lvl
);
  // A fresh event wins over the clear of the record being served (R8).
  always_ff @(posedge clk) begin
    if (rst) begin
      p_rst <= 1'b0;
      p_nmi <= 1'b0;
      p_st  <= LV_IDLE;
      p_lvl <= '0;
    end else begin
      if (take_rst) p_rst <= 1'b0;
      if (ev_rst)   p_rst <= 1'b1;
      if (take_nmi) p_nmi <= 1'b0;
      if (ev_nmi)   p_nmi <= 1'b1;
      if (take_lvl) p_st  <= LV_IDLE;
      if (ev_lvl) begin
        p_st  <= (ev_lvl_val == '0) ? LV_CLR : LV_SET;
        p_lvl <= ev_lvl_val;
      end
    end
  end
endmodule

// File: rtl/idu_arbiter.sv
module idu_arbiter
  import idu_pkg::*;
#(
  parameter int LW = 6
) (
  input  logic          p_rst,
  input  logic          p_nmi,
  input  lvl_st_e       p_st,
  input  logic [LW-1:0] p_lvl,
  input  logic          ie,
  input  logic [LW-1:0] mask,
  output logic          take_rst,
  output logic          take_nmi,
  output logic          take_lvl,
  output logic          fire_rn,
  output logic          fire_irq,
  output logic          cause_ld,
  output logic [LW-1:0] cause_nx
);
  logic lvl_turn;
  logic unmasked;

  assign unmasked = ie && ((p_lvl & mask) != '0);
  assign lvl_turn = !p_rst && !p_nmi && (p_st != LV_IDLE);

  always_comb begin
    take_rst = p_rst;
    take_nmi = !p_rst && p_nmi;
    fire_rn  = take_rst || take_nmi;
    cause_ld = lvl_turn;
    cause_nx = (p_st == LV_SET) ? p_lvl : '0;
    fire_irq = lvl_turn && (p_st == LV_SET) && unmasked;
    take_lvl = lvl_turn && ((p_st == LV_CLR) || unmasked);
  end
endmodule

// File: rtl/idu_outreg.sv
module idu_outreg #(
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire_rn,
  input  logic          fire_irq,
  input  logic          cause_ld,
  input  logic [LW-1:0] cause_nx,
  output logic          resnmi_o,
  output logic          irq_o,
  output logic [LW-1:0] cause_ip_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      resnmi_o   <= 1'b0;
      irq_o      <= 1'b0;
      cause_ip_o <= '0;
    end else begin
      resnmi_o <= fire_rn;
      irq_o    <= fire_irq;
      if (cause_ld) cause_ip_o <= cause_nx;
    end
  end

  AST_SINGLE_EXC: assert property (@(posedge clk) disable iff (rst)
    !(resnmi_o && irq_o)); // R9
endmodule

// File: rtl/irq_delivery_unit.sv
module irq_delivery_unit
  import idu_pkg::*;
#(
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rst_req_i,
  input  logic          nmi_req_i,
  input  logic          lvl_vld_i,
  input  logic [LW-1:0] lvl_i,
  input  logic          ie_i,
  input  logic [LW-1:0] mask_i,
  output logic          resnmi_o,
  output logic          irq_o,
  output logic [LW-1:0] cause_ip_o
);
  logic          p_rst, p_nmi;
  lvl_st_e       p_st;
  logic [LW-1:0] p_lvl;
  logic          take_rst, take_nmi, take_lvl;
  logic          fire_rn, fire_irq, cause_ld;
  logic [LW-1:0] cause_nx;

  idu_pending #(.LW(LW)) u_pend (
    .clk(clk), .rst(rst),
    .ev_rst(rst_req_i), .ev_nmi(nmi_req_i),
    .ev_lvl(lvl_vld_i), .ev_lvl_val(lvl_i),
    .take_rst(take_rst), .take_nmi(take_nmi), .take_lvl(take_lvl),
    .p_rst(p_rst), .p_nmi(p_nmi), .p_st(p_st), .p_lvl(p_lvl)
  );

  idu_arbiter #(.LW(LW)) u_arb (
    .p_rst(p_rst), .p_nmi(p_nmi), .p_st(p_st), .p_lvl(p_lvl),
    .ie(ie_i), .mask(mask_i),
    .take_rst(take_rst), .take_nmi(take_nmi), .take_lvl(take_lvl),
    .fire_rn(fire_rn), .fire_irq(fire_irq),
    .cause_ld(cause_ld), .cause_nx(cause_nx)
  );

  idu_outreg #(.LW(LW)) u_out (
    .clk(clk), .rst(rst),
    .fire_rn(fire_rn), .fire_irq(fire_irq),
    .cause_ld(cause_ld), .cause_nx(cause_nx),
    .resnmi_o(resnmi_o), .irq_o(irq_o), .cause_ip_o(cause_ip_o)
  );

  AST_RST_FIRST: assert property (@(posedge clk) disable iff (rst)
    p_rst |=> (resnmi_o && !irq_o)); // R3
  AST_NMI_NEXT: assert property (@(posedge clk) disable iff (rst)
    (!p_rst && p_nmi) |=> resnmi_o); // R3
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ie_i && ((p_lvl & mask_i) != '0) && (p_st == LV_SET)
                    && !p_rst && !p_nmi)); // R6
  AST_EOI_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((p_st == LV_CLR) && !p_rst && !p_nmi) |=> (!irq_o && (cause_ip_o == '0))); // R5
  AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((p_st == LV_SET) && !p_rst && !p_nmi && !lvl_vld_i
     && !(ie_i && ((p_lvl & mask_i) != '0))) |=> (p_st == LV_SET)); // R7
  AST_CAUSE_STILL: assert property (@(posedge clk) disable iff (rst)
    ((p_st == LV_IDLE) || p_rst || p_nmi) |=> $stable(cause_ip_o)); // R4
endmodule

// File: tb/irq_delivery_unit_bench.sv
module irq_delivery_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rst_req_i = 1'b0, nmi_req_i = 1'b0, lvl_vld_i = 1'b0;
  logic [5:0] lvl_i = '0;
  logic       ie_i = 1'b0;
  logic [5:0] mask_i = '0;
  logic       resnmi_o, irq_o;
  logic [5:0] cause_ip_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk; // 250 MHz

  irq_delivery_unit u_irq_delivery_unit (
    .clk(clk), .rst(rst), .rst_req_i(rst_req_i), .nmi_req_i(nmi_req_i),
    .lvl_vld_i(lvl_vld_i), .lvl_i(lvl_i), .ie_i(ie_i), .mask_i(mask_i),
    .resnmi_o(resnmi_o), .irq_o(irq_o), .cause_ip_o(cause_ip_o)
  );

  typedef struct packed {
    logic       rr;
    logic       nr;
    logic       lv;
    logic [5:0] lvl;
    logic       ie;
    logic [5:0] mask;
    logic [1:0] n_rn;
    logic [1:0] n_irq;
    logic [5:0] cause;
  } vec_t;

  localparam int NV = 8;
  // Vectors run back to back; each spans two clock edges after its event.
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b1,6'h05,1'b1,6'h04,2'd0,2'd1,6'h05}, // R6 delivered, R4 cause
    '{1'b0,1'b0,1'b1,6'h00,1'b1,6'h3f,2'd0,2'd0,6'h00}, // R5 end of interrupt
    '{1'b0,1'b0,1'b1,6'h20,1'b0,6'h3f,2'd0,2'd0,6'h20}, // R4 disabled, cause still set
    '{1'b0,1'b0,1'b0,6'h00,1'b1,6'h3f,2'd0,2'd1,6'h20}, // R7 retried and delivered
    '{1'b0,1'b0,1'b1,6'h03,1'b1,6'h0c,2'd0,2'd0,6'h03}, // R6 masked line
    '{1'b0,1'b0,1'b1,6'h00,1'b1,6'h0c,2'd0,2'd0,6'h00}, // R5 ends masked level
    '{1'b0,1'b1,1'b0,6'h00,1'b1,6'h3f,2'd1,2'd0,6'h00}, // R3 non-maskable
    '{1'b1,1'b0,1'b0,6'h00,1'b1,6'h3f,2'd1,2'd0,6'h00}  // R2 reset request
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic rr, input logic nr, input logic lv, input logic [5:0] l);
    rst_req_i = rr; nmi_req_i = nr; lvl_vld_i = lv; lvl_i = l;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int rn_cnt, irq_cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset resnmi", {7'd0, resnmi_o}, 8'd0);
    check("R1 reset irq", {7'd0, irq_o}, 8'd0);
    check("R1 reset cause", {2'd0, cause_ip_o}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      ie_i = VECS[i].ie; mask_i = VECS[i].mask;
      drive(VECS[i].rr, VECS[i].nr, VECS[i].lv, VECS[i].lvl);
      rn_cnt = 0; irq_cnt = 0;
      @(negedge clk);
      rn_cnt += resnmi_o; irq_cnt += irq_o;
      drive(1'b0, 1'b0, 1'b0, 6'h00);
      @(negedge clk);
      rn_cnt += resnmi_o; irq_cnt += irq_o;
      check($sformatf("R2/R3 vec%0d resnmi count", i), 8'(rn_cnt), {6'd0, VECS[i].n_rn});
      check($sformatf("R6/R7 vec%0d irq count", i), 8'(irq_cnt), {6'd0, VECS[i].n_irq});
      check($sformatf("R4/R5 vec%0d cause", i), {2'd0, cause_ip_o}, {2'd0, VECS[i].cause});
    end
    // R2 strobe lasts one cycle
    @(negedge clk);
    check("R2 strobe single cycle", {7'd0, resnmi_o}, 8'd0);

    // R3 all three captured together
    ie_i = 1'b1; mask_i = 6'h3f;
    drive(1'b1, 1'b1, 1'b1, 6'h01);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 6'h00);
    @(negedge clk);
    check("R3 first resnmi", {6'd0, resnmi_o, irq_o}, 8'b10);
    @(negedge clk);
    check("R3 second resnmi", {6'd0, resnmi_o, irq_o}, 8'b10);
    @(negedge clk);
    check("R3 level last", {6'd0, resnmi_o, irq_o}, 8'b01);
    check("R3 level cause", {2'd0, cause_ip_o}, 8'h01);
    @(negedge clk);
    check("R9 quiet after", {6'd0, resnmi_o, irq_o}, 8'b00);

    // R8 new level in the serving cycle
    drive(1'b0, 1'b0, 1'b1, 6'h04);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b1, 6'h02);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 6'h00);
    check("R8 first irq", {7'd0, irq_o}, 8'd1);
    check("R8 first cause", {2'd0, cause_ip_o}, 8'h04);
    @(negedge clk);
    check("R8 second irq", {7'd0, irq_o}, 8'd1);
    check("R8 second cause", {2'd0, cause_ip_o}, 8'h02);
    @(negedge clk);
    check("R6 no repeat", {7'd0, irq_o}, 8'd0);

    // R7 long wait while disabled
    ie_i = 1'b0;
    drive(1'b0, 1'b0, 1'b1, 6'h10);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 6'h00);
    irq_cnt = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      irq_cnt += irq_o;
    end
    check("R7 held while disabled", 8'(irq_cnt), 8'd0);
    check("R4 cause while held", {2'd0, cause_ip_o}, 8'h10);
    ie_i = 1'b1;
    irq_cnt = 0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      irq_cnt += irq_o;
    end
    check("R7 delivered once enabled", 8'(irq_cnt), 8'd1);

    // R1 block reset drops a pending level
    ie_i = 1'b0;
    drive(1'b0, 1'b0, 1'b1, 6'h08);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 6'h00);
    @(negedge clk);
    @(negedge clk);
    check("R4 cause before reset", {2'd0, cause_ip_o}, 8'h08);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 cause cleared", {2'd0, cause_ip_o}, 8'h00);
    ie_i = 1'b1;
    irq_cnt = 0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      irq_cnt += irq_o;
    end
    check("R1 dropped level", 8'(irq_cnt), 8'd0);
    check("R1 cause stays zero", {2'd0, cause_ip_o}, 8'h00);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule